// File: doc/BRIEF.md
# Dominant Timeout Filter

This block is a per-signal timer stage that sits between one active-low dominant source and the bus logic unit. Four copies are used: one on the local transmit input, one on the expansion transmit input and one on each of the two bus receivers. Every copy runs its own timer, with no state shared between copies. A dominant level (logic 0) passes through to the output one clock later, and a recessive level (logic 1) passes through the same way. If the input stays dominant for longer than a programmable number of cycles, the output is forced recessive. This stops a stuck node from blocking the bus.

The interval comes from a `limit` input. Its value is clamped into a legal window, which is 250 to 750 cycles by default. The value is captured on every recessive sample, so it stays fixed for the whole of a dominant run. After reset the interval is 450 cycles until the first recessive sample loads a new one. Once the output is forced, it stays recessive and a timeout flag stays high. Both hold until the input returns recessive. The next dominant run then times from zero.

Top module: `dominant_timeout_filter`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `dout_n` is 1 (recessive) and `tmo_flag` is 0. The captured interval resets to DEF_LIMIT (450).
- R2: Logic 0 on `din_n` means dominant. For the first L consecutive dominant samples of a run, `dout_n` shows 0 one clock after each sample, where L is the captured interval.
- R3: On dominant sample number L+1 of a run, and on every later dominant sample of that run, `dout_n` is driven to 1 one clock later.
- R4: Any recessive sample on `din_n` gives `dout_n`=1 and `tmo_flag`=0 one clock later. It also clears the timer, so the following dominant run again passes L samples.
- R5: The captured interval is `limit` clamped into [MIN_LIMIT, MAX_LIMIT], which is [250, 750] by default.
- R6: `limit` is captured only on recessive samples. Changes to `limit` while `din_n` is dominant have no effect on the current run.
- R7: `tmo_flag` is 1 exactly when the output is being forced recessive by a timeout. Whenever `tmo_flag` is 1, `dout_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-on reset hold) |
| limit | input | LIM_W (11) | Requested timeout interval in cycles, clamped internally |
| din_n | input | 1 | Active-low input: 0 is dominant, 1 is recessive |
| dout_n | output | 1 | Active-low filtered output, registered |
| tmo_flag | output | 1 | High while the output is forced recessive by a timeout |

## Verification
Each input sample taken at a rising edge is reflected on `dout_n` and `tmo_flag` right after that same edge, so both results are due one cycle after the stimulus. The bench drives `din_n` and `limit` at the falling edge and updates its model at the following rising edge. It compares both outputs at the next falling edge, away from any edge at which inputs change. The model counts the length of the dominant run and captures the interval on recessive samples. This makes the expected forcing point fall exactly on dominant sample L+1.

// File: rtl/dtf_pkg.sv
package dtf_pkg;

  // Clamp a requested interval into the legal window.
  function automatic int unsigned clamp_limit(input int unsigned req,
                                              input int unsigned lo,
                                              input int unsigned hi);
    if (req < lo) return lo;
    if (req > hi) return hi;
    return req;
  endfunction

endpackage

// File: rtl/dtf_limit_latch.sv
module dtf_limit_latch
  import dtf_pkg::*;
#(
  parameter int unsigned MIN_LIMIT = 250,
  parameter int unsigned MAX_LIMIT = 750,
  parameter int unsigned DEF_LIMIT = 450,
  parameter int unsigned CNT_W     = 10,
  parameter int unsigned LIM_W     = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LIM_W-1:0] limit,
  input  logic             din_n,
  output logic [CNT_W-1:0] lim_q
);

  logic [CNT_W-1:0] lim_clamped;

  always_comb begin
    lim_clamped = CNT_W'(clamp_limit(int'(limit), MIN_LIMIT, MAX_LIMIT));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lim_q <= CNT_W'(DEF_LIMIT);
    end else if (din_n) begin
      lim_q <= lim_clamped;
    end
  end

  AST_LIM_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    (lim_q >= CNT_W'(MIN_LIMIT)) && (lim_q <= CNT_W'(MAX_LIMIT))); // R5

  AST_LIM_HELD_DOM: assert property (@(posedge clk) disable iff (rst)
    !din_n |=> $stable(lim_q)); // R6

endmodule

// File: rtl/dtf_run_counter.sv
module dtf_run_counter #(
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             din_n,
  input  logic [CNT_W-1:0] lim_q,
  output logic             hit_now
);

  logic [CNT_W-1:0] cnt;
  logic             blk;

  // The current dominant sample is past the interval.
  always_comb begin
    hit_now = !din_n && (blk || (cnt == lim_q));
  end

  always_ff @(posedge clk) begin
    if (rst || din_n) begin
      cnt <= '0;
      blk <= 1'b0;
    end else if (!blk) begin
      if (cnt == lim_q) begin
        blk <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  AST_CNT_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    cnt <= lim_q); // R3

  AST_BLK_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (blk && !din_n) |=> blk); // R3

  AST_REC_CLEARS_CNT: assert property (@(posedge clk) disable iff (rst)
    din_n |=> (cnt == '0) && !blk); // R4

endmodule

// File: rtl/dtf_out_stage.sv
module dtf_out_stage (
  input  logic clk,
  input  logic rst,
  input  logic din_n,
  input  logic hit_now,
  output logic dout_n,
  output logic tmo_flag
);

  always_ff @(posedge clk) begin
    if (rst) begin
      dout_n   <= 1'b1;
      tmo_flag <= 1'b0;
    end else begin
      dout_n   <= din_n | hit_now;
      tmo_flag <= !din_n & hit_now;
    end
  end

  AST_FLAG_FORCES_REC: assert property (@(posedge clk) disable iff (rst)
    tmo_flag |-> dout_n); // R7

  AST_REC_PASSES: assert property (@(posedge clk) disable iff (rst)
    din_n |=> dout_n && !tmo_flag); // R4

  AST_DOM_PASSES: assert property (@(posedge clk) disable iff (rst)
    (!din_n && !hit_now) |=> !dout_n); // R2

endmodule

// File: rtl/dominant_timeout_filter.sv
module dominant_timeout_filter #(
  parameter int unsigned MIN_LIMIT = 250,
  parameter int unsigned MAX_LIMIT = 750,
  parameter int unsigned DEF_LIMIT = 450,
  parameter int unsigned LIM_W     = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LIM_W-1:0] limit,
  input  logic             din_n,
  output logic             dout_n,
  output logic             tmo_flag
);

  localparam int unsigned CNT_W = $clog2(MAX_LIMIT + 1);

  logic [CNT_W-1:0] lim_q;
  logic             hit_now;

  dtf_limit_latch #(
    .MIN_LIMIT(MIN_LIMIT),
    .MAX_LIMIT(MAX_LIMIT),
    .DEF_LIMIT(DEF_LIMIT),
    .CNT_W    (CNT_W),
    .LIM_W    (LIM_W)
  ) u_lim (
    .clk  (clk),
    .rst  (rst),
    .limit(limit),
    .din_n(din_n),
    .lim_q(lim_q)
  );

  dtf_run_counter #(
    .CNT_W(CNT_W)
  ) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .din_n  (din_n),
    .lim_q  (lim_q),
    .hit_now(hit_now)
  );

  dtf_out_stage u_out (
    .clk     (clk),
    .rst     (rst),
    .din_n   (din_n),
    .hit_now (hit_now),
    .dout_n  (dout_n),
    .tmo_flag(tmo_flag)
  );

  AST_RESET_REC: assert property (@(posedge clk)
    $past(rst) |-> dout_n && !tmo_flag); // R1

endmodule

// File: tb/dominant_timeout_filter_test.sv
`timescale 1ns/1ps
module dominant_timeout_filter_test;

  localparam int MINL = 250;
  localparam int MAXL = 750;
  localparam int DEFL = 450;
  localparam int LW   = 11;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [LW-1:0] limit = '0;
  logic          din_n = 1'b1;
  logic          dout_n;
  logic          tmo_flag;

  int checks = 0;
  int fails  = 0;
  int run    = 0;
  int lim_m  = DEFL;
  int cycles = 0;
  string ptag = "";

  always #2.5 clk = ~clk;

  dominant_timeout_filter uut (
    .clk(clk), .rst(rst), .limit(limit), .din_n(din_n),
    .dout_n(dout_n), .tmo_flag(tmo_flag)
  );

  function automatic int clampf(input int r);
    if (r < MINL) return MINL;
    if (r > MAXL) return MAXL;
    return r;
  endfunction

  task automatic check(input string tag, input logic act_o, input logic exp_o,
                       input logic act_f, input logic exp_f);
    checks++;
    if (act_o !== exp_o || act_f !== exp_f) begin
      fails++;
      $display("FAIL %s%s: dout_n=%b exp %b, tmo_flag=%b exp %b (run=%0d lim=%0d)",
               tag, ptag, act_o, exp_o, act_f, exp_f, run, lim_m);
    end
  endtask

  // One cycle: drive at the falling edge, model at the rising edge, compare at the next falling edge.
  task automatic cyc(input logic r, input logic d, input int l);
    logic eo, ef;
    string tag;
    rst = r; din_n = d; limit = LW'(l);
    @(posedge clk);
    if (r) begin
      run = 0; lim_m = DEFL; eo = 1'b1; ef = 1'b0; tag = "R1";
    end else if (d) begin
      run = 0; lim_m = clampf(l); eo = 1'b1; ef = 1'b0; tag = "R4";
    end else begin
      if (run < 100000) run++;
      eo = (run <= lim_m) ? 1'b0 : 1'b1;
      ef = (run > lim_m);
      tag = (run <= lim_m) ? "R2" : "R3/R7";
    end
    @(negedge clk);
    check(tag, dout_n, eo, tmo_flag, ef);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: cycles=%0d exp below 150000", cycles);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    @(negedge clk);
    // R1: reset state
    ptag = " reset";
    for (int i = 0; i < 4; i++) cyc(1'b1, 1'b0, 0);
    // R1/R2/R3: default interval right after reset (no recessive sample yet)
    ptag = " default";
    for (int i = 0; i < DEFL + 10; i++) cyc(1'b0, 1'b0, 600);
    // R5: low request clamps to MINL
    ptag = " R5 low clamp";
    cyc(1'b0, 1'b1, 10); cyc(1'b0, 1'b1, 100);
    for (int i = 0; i < MINL + 5; i++) cyc(1'b0, 1'b0, 100);
    // R5: high request clamps to MAXL
    ptag = " R5 high clamp";
    cyc(1'b0, 1'b1, 2000);
    for (int i = 0; i < MAXL + 5; i++) cyc(1'b0, 1'b0, 2000);
    // R6: limit changes during a dominant run are ignored
    ptag = " R6 hold";
    cyc(1'b0, 1'b1, 300);
    for (int i = 0; i < 310; i++) cyc(1'b0, 1'b0, (i < 5) ? 300 : 700);
    // R4: single recessive sample restarts timing from zero
    ptag = " R4 restart";
    cyc(1'b0, 1'b1, 260);
    for (int i = 0; i < 262; i++) cyc(1'b0, 1'b0, 260);
    cyc(1'b0, 1'b1, 260);
    for (int i = 0; i < 262; i++) cyc(1'b0, 1'b0, 260);
    // Short glitches
    ptag = " R2 glitch";
    for (int i = 0; i < 40; i++) cyc(1'b0, i[0], 400);
    // Constrained random bursts
    ptag = " random";
    for (int b = 0; b < 60; b++) begin
      int dl, rl, lv;
      dl = int'($urandom_range(1, 800));
      rl = int'($urandom_range(1, 4));
      lv = int'($urandom_range(0, 1100));
      for (int i = 0; i < rl; i++) cyc(1'b0, 1'b1, lv);
      for (int i = 0; i < dl; i++) cyc(1'b0, 1'b0, int'($urandom_range(0, 1100)));
    end
    // Mid-run reset returns to default state
    ptag = " R1 midrun";
    cyc(1'b1, 1'b0, 0);
    cyc(1'b0, 1'b0, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule